// File: doc/BRIEF.md
# Sequencer Control Register Interface

This block is the host-facing register file of a pattern sequencer. A simple word-addressed bus (byte address, write strobe, read strobe, 32-bit data) reaches a small set of registers. They hold run control, a scratch word, the program slot pointer, four staging words for one 128-bit instruction, a per-channel output polarity mask and a fixed version word. The sequencer core and its program memory sit on the other side. The register file presents a memory write port, a memory read address, a one-cycle start pulse and a reset level to them.

Software selects a slot and fills the three lower staging words. It then writes the top word, and that single write commits all 128 bits into the selected slot at once. A run is started either by software, or by a rising edge on an external start input when the block is armed. The external input is synchronized first. Edges that arrive while the program runs are ignored.

Top module: `seq_ctrl_regs`

## Requirements
- R1: After a cycle with rst_n low, bus_rdata, seq_start, seq_reset and prog_we are 0, the inversion mask is 0 (chan_out equals pat_in), and the control word reads 0 while seq_running is 0.
- R2: The scratch word at offset 0x04 reads back exactly the last value written to it (for example 0xBEEFBEEF).
- R3: The slot pointer at offset 0x08 keeps the low SLOT_W bits of the written value and reads back zero-extended. mem_raddr always equals the slot pointer.
- R4: Writes to offsets 0x0C, 0x10 and 0x14 only stage instruction words 0, 1 and 2 and do not pulse prog_we. A write to 0x18 pulses prog_we for exactly the following cycle, with prog_waddr equal to the slot pointer and prog_wdata = {written word, word 2, word 1, word 0}.
- R5: Reads of offsets 0x0C, 0x10, 0x14 and 0x18 return bits [31:0], [63:32], [95:64] and [127:96] of mem_rdata for the currently addressed slot.
- R6: Control offset 0x00 has bit 0 = go, bit 2 = arm, bit 3 = hold. A write with bit 0 = 1, bit 2 = 0 and bit 3 = 0 while seq_running is 0 gives a seq_start pulse in the next cycle. Read back, bit 0 shows seq_running, bits 2 and 3 show the stored arm and hold bits, and all other bits read 0.
- R7: While arm is 1, software go writes are ignored. Suppose ext_start is sampled high at one clock edge after being low at the one before. seq_start is then high in the cycle that follows the second edge after that.
- R8: No start pulse is produced while seq_running is 1, and no external edge starts a run while arm is 0.
- R9: seq_reset equals the stored hold bit. No start of either kind is produced while hold is set, including the cycle of the write that sets it.
- R10: The mask at offset 0x1C reads back as written, and chan_out = pat_in XOR mask for every channel.
- R11: Offset 0x20 always reads VERSION, and writes to it have no effect.
- R12: Unmapped or misaligned offsets read 0, and writes to them change no register.
- R13: seq_start is never high in two consecutive cycles. bus_rdata is 0 in every cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | BUS_AW | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, data returned next cycle |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, registered |
| prog_we | output | 1 | Program memory write enable |
| prog_waddr | output | SLOT_W | Program memory write slot |
| prog_wdata | output | NW*DW | Full instruction to commit |
| mem_raddr | output | SLOT_W | Program memory read slot |
| mem_rdata | input | NW*DW | Program memory read data (combinational) |
| seq_running | input | 1 | Sequencer busy flag |
| seq_start | output | 1 | One-cycle start request, run from slot 0 |
| seq_reset | output | 1 | Holds the sequencer in reset |
| ext_start | input | 1 | Asynchronous external start |
| pat_in | input | CH | Raw channel pattern from the sequencer |
| chan_out | output | CH | Pattern after polarity inversion |

## Verification
Register access is tried with distinct values in each register, with all-ones into the narrow slot pointer, and with misaligned and unmapped offsets. These show decode aliasing and width truncation. Commits are tried with a distinct value in every staging word, and then read back through a second slot. This shows word ordering and whether the lower writes leak into memory. Starts are tried by software, by armed and unarmed external edges, during a run, and under hold, including a write that sets hold and go together. These separate the gating terms and measure the synchronizer latency to the exact cycle.

// File: rtl/seq_regs_pkg.sv
// Package: shared offsets, control bit positions and register selector type
// for the sequencer control register interface. Assumes a byte-addressed
// bus with 32-bit aligned registers.
package seq_regs_pkg;
    localparam int unsigned OFS_CTRL  = 32'h00;
    localparam int unsigned OFS_TEST  = 32'h04;
    localparam int unsigned OFS_SLOT  = 32'h08;
    localparam int unsigned OFS_W0    = 32'h0C;
    localparam int unsigned OFS_W1    = 32'h10;
    localparam int unsigned OFS_W2    = 32'h14;
    localparam int unsigned OFS_W3    = 32'h18;
    localparam int unsigned OFS_INV   = 32'h1C;
    localparam int unsigned OFS_VER   = 32'h20;

    localparam int unsigned CTL_GO    = 0;
    localparam int unsigned CTL_ARM   = 2;
    localparam int unsigned CTL_HOLD  = 3;

    typedef enum logic [3:0] {
        SEL_CTRL, SEL_TEST, SEL_SLOT, SEL_W0, SEL_W1,
        SEL_W2, SEL_W3, SEL_INV, SEL_VER, SEL_NONE
    } reg_sel_e;
endpackage

// File: rtl/seq_start_ctl.sv
// Module: start request generator. Synchronizes the asynchronous external
// start, detects its rising edge, and merges it with the software request.
// Assumes SYNC_STAGES >= 2. A start is suppressed while the sequencer runs,
// while hold is (or is about to be) set, and in the cycle after a start.
module seq_start_ctl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_in,
    input  logic arm,
    input  logic sw_req,
    input  logic hold_next,
    input  logic running,
    output logic start
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0] sync_q;
    logic         prev_q;
    logic         start_q;
    logic         ext_rise;

    // Synchronizer chain and edge history for the external start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[MSB-1:0], ext_in};
            prev_q <= sync_q[MSB];
        end
    end

    // Rising edge of the synchronized input.
    always_comb ext_rise = sync_q[MSB] & ~prev_q;

    // One-cycle start pulse with all blocking conditions applied.
    always_ff @(posedge clk) begin
        if (!rst_n) start_q <= 1'b0;
        else        start_q <= (sw_req | (arm & ext_rise)) & ~hold_next
                               & ~running & ~start_q;
    end

    assign start = start_q;

    p_single_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);
    p_no_start_running_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !$past(running));
endmodule

// File: rtl/seq_instr_stage.sv
// Module: instruction staging and commit. Holds the lower NW-1 words of an
// instruction. A write of the top word commits all words to the slot given
// by the pointer, registered, in the following cycle.
module seq_instr_stage #(
    parameter int DW     = 32,
    parameter int NW     = 4,
    parameter int SLOT_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [$clog2(NW)-1:0] wr_idx,
    input  logic [DW-1:0]       wdata,
    input  logic [SLOT_W-1:0]   slot,
    output logic                prog_we,
    output logic [SLOT_W-1:0]   prog_waddr,
    output logic [NW*DW-1:0]    prog_wdata
);
    localparam int IDX_W = $clog2(NW);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NW - 1);

    logic [NW-2:0][DW-1:0] stage_q;
    logic                  top_wr;

    always_comb top_wr = wr_en && (wr_idx == TOP_IDX);

    // Capture lower staging words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            for (int i = 0; i < NW - 1; i++) begin
                if (wr_en && wr_idx == IDX_W'(i)) stage_q[i] <= wdata;
            end
        end
    end

    // Commit the full instruction on a top-word write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_we    <= 1'b0;
            prog_waddr <= '0;
            prog_wdata <= '0;
        end else begin
            prog_we <= top_wr;
            if (top_wr) begin
                prog_waddr <= slot;
                prog_wdata <= {wdata, stage_q};
            end
        end
    end

    p_commit_only_on_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
        prog_we |-> $past(wr_en) && $past(wr_idx) == TOP_IDX);
    p_commit_top_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        prog_we |-> prog_wdata[NW*DW-1 -: DW] == $past(wdata));
    p_lower_no_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && wr_idx != TOP_IDX) |-> !prog_we);
endmodule

// File: rtl/seq_ctrl_regs.sv
// Module: top of the sequencer control register interface. Decodes the
// host bus, holds control, scratch, slot pointer and polarity registers,
// returns registered read data (zero when not reading), and drives the
// program memory ports and run control of the sequencer core.
// Assumes one access per cycle and a combinational memory read port.
module seq_ctrl_regs
    import seq_regs_pkg::*;
#(
    parameter int          DW          = 32,
    parameter int          NW          = 4,
    parameter int          BUS_AW      = 8,
    parameter int          SLOT_W      = 12,
    parameter int          CH          = 32,
    parameter int          SYNC_STAGES = 2,
    parameter logic [31:0] VERSION     = 32'h5EC0_0107
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              prog_we,
    output logic [SLOT_W-1:0] prog_waddr,
    output logic [NW*DW-1:0]  prog_wdata,
    output logic [SLOT_W-1:0] mem_raddr,
    input  logic [NW*DW-1:0]  mem_rdata,
    input  logic              seq_running,
    output logic              seq_start,
    output logic              seq_reset,
    input  logic              ext_start,
    input  logic [CH-1:0]     pat_in,
    output logic [CH-1:0]     chan_out
);
    localparam int IDX_W = $clog2(NW);

    reg_sel_e          sel;
    logic [DW-1:0]     test_q;
    logic [SLOT_W-1:0] slot_q;
    logic              arm_q;
    logic              hold_q;
    logic [CH-1:0]     inv_q;
    logic [DW-1:0]     rdata_q;
    logic [DW-1:0]     rd_mux;
    logic              wr_ctrl;
    logic              wr_word;
    logic [IDX_W-1:0]  word_idx;
    logic              sw_req;
    logic              hold_next;

    // Address decode to a register selector.
    always_comb begin
        sel = SEL_NONE;
        if      (bus_addr == BUS_AW'(OFS_CTRL)) sel = SEL_CTRL;
        else if (bus_addr == BUS_AW'(OFS_TEST)) sel = SEL_TEST;
        else if (bus_addr == BUS_AW'(OFS_SLOT)) sel = SEL_SLOT;
        else if (bus_addr == BUS_AW'(OFS_W0))   sel = SEL_W0;
        else if (bus_addr == BUS_AW'(OFS_W1))   sel = SEL_W1;
        else if (bus_addr == BUS_AW'(OFS_W2))   sel = SEL_W2;
        else if (bus_addr == BUS_AW'(OFS_W3))   sel = SEL_W3;
        else if (bus_addr == BUS_AW'(OFS_INV))  sel = SEL_INV;
        else if (bus_addr == BUS_AW'(OFS_VER))  sel = SEL_VER;
    end

    // Instruction word write strobe and word index.
    always_comb begin
        wr_word  = bus_wr && (sel == SEL_W0 || sel == SEL_W1 ||
                              sel == SEL_W2 || sel == SEL_W3);
        word_idx = IDX_W'(sel - SEL_W0);
    end

    // Control write decode: software request and next hold value.
    always_comb begin
        wr_ctrl   = bus_wr && sel == SEL_CTRL;
        sw_req    = wr_ctrl && bus_wdata[CTL_GO] && !bus_wdata[CTL_ARM];
        hold_next = wr_ctrl ? bus_wdata[CTL_HOLD] : hold_q;
    end

    // Writable host registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            test_q <= '0;
            slot_q <= '0;
            arm_q  <= 1'b0;
            hold_q <= 1'b0;
            inv_q  <= '0;
        end else if (bus_wr) begin
            case (sel)
                SEL_CTRL: begin
                    arm_q  <= bus_wdata[CTL_ARM];
                    hold_q <= bus_wdata[CTL_HOLD];
                end
                SEL_TEST: test_q <= bus_wdata;
                SEL_SLOT: slot_q <= bus_wdata[SLOT_W-1:0];
                SEL_INV:  inv_q  <= bus_wdata[CH-1:0];
                default:  ;
            endcase
        end
    end

    // Read data selection.
    always_comb begin
        rd_mux = '0;
        case (sel)
            SEL_CTRL: begin
                rd_mux[CTL_GO]   = seq_running;
                rd_mux[CTL_ARM]  = arm_q;
                rd_mux[CTL_HOLD] = hold_q;
            end
            SEL_TEST: rd_mux = test_q;
            SEL_SLOT: rd_mux = DW'(slot_q);
            SEL_W0:   rd_mux = mem_rdata[0*DW +: DW];
            SEL_W1:   rd_mux = mem_rdata[1*DW +: DW];
            SEL_W2:   rd_mux = mem_rdata[2*DW +: DW];
            SEL_W3:   rd_mux = mem_rdata[3*DW +: DW];
            SEL_INV:  rd_mux = DW'(inv_q);
            SEL_VER:  rd_mux = DW'(VERSION);
            default:  rd_mux = '0;
        endcase
    end

    // Registered read data, zero outside a read response.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= bus_rd ? rd_mux : '0;
    end

    seq_instr_stage #(.DW(DW), .NW(NW), .SLOT_W(SLOT_W)) u_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_word),
        .wr_idx     (word_idx),
        .wdata      (bus_wdata),
        .slot       (slot_q),
        .prog_we    (prog_we),
        .prog_waddr (prog_waddr),
        .prog_wdata (prog_wdata)
    );

    seq_start_ctl #(.SYNC_STAGES(SYNC_STAGES)) u_start (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_in    (ext_start),
        .arm       (arm_q),
        .sw_req    (sw_req),
        .hold_next (hold_next),
        .running   (seq_running),
        .start     (seq_start)
    );

    assign bus_rdata = rdata_q;
    assign mem_raddr = slot_q;
    assign seq_reset = hold_q;
    assign chan_out  = pat_in ^ inv_q;

    p_hold_blocks_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |-> !seq_reset);
    p_unmapped_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_rd && sel == SEL_NONE) |-> bus_rdata == '0);
    p_version_fixed_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_rd && sel == SEL_VER) |-> bus_rdata == DW'(VERSION));
    p_idle_rdata_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_rd) |-> bus_rdata == '0);
    p_scratch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_wr && sel == SEL_TEST) |-> $stable(test_q));
endmodule

// File: tb/sim_seq_ctrl_regs.sv
// Bench: behavioural reference model compared on every clock, plus
// directed checks per requirement. The bench also acts as program memory.
module sim_seq_ctrl_regs;
    localparam int DW = 32, NW = 4, AW = 8, SW = 12, CH = 32;
    localparam logic [31:0] VER = 32'h5EC0_0107;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [DW-1:0] bus_wdata = '0, bus_rdata;
    logic prog_we;
    logic [SW-1:0] prog_waddr, mem_raddr;
    logic [NW*DW-1:0] prog_wdata, mem_rdata;
    logic seq_running = 1'b0, seq_start, seq_reset, ext_start = 1'b0;
    logic [CH-1:0] pat_in = '0, chan_out;

    int total = 0, bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    seq_ctrl_regs u0 (.*);

    // Program memory model.
    logic [NW*DW-1:0] mem [0:(1<<SW)-1];
    initial for (int i = 0; i < (1 << SW); i++) mem[i] = '0;
    always @(negedge clk) if (prog_we) mem[prog_waddr] = prog_wdata;
    assign mem_rdata = mem[mem_raddr];

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model state.
    logic [31:0] m_test, m_lo, m_med, m_hi, m_inv, m_rdata;
    logic [SW-1:0] m_slot, m_waddr;
    logic m_arm, m_hold, m_start, m_we, e1, e2, e3;
    logic [127:0] m_wdata;
    logic hold_nx, sw, ex;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_test = 0; m_lo = 0; m_med = 0; m_hi = 0; m_inv = 0; m_rdata = 0;
            m_slot = 0; m_arm = 0; m_hold = 0; m_start = 0; m_we = 0;
            e1 = 0; e2 = 0; e3 = 0; m_wdata = 0; m_waddr = 0;
        end else begin
            hold_nx = (bus_wr && bus_addr == 8'h00) ? bus_wdata[3] : m_hold;
            sw = bus_wr && bus_addr == 8'h00 && bus_wdata[0] && !bus_wdata[2];
            ex = m_arm && e2 && !e3;
            m_rdata = 0;
            if (bus_rd) case (bus_addr)
                8'h00: m_rdata = {28'd0, m_hold, m_arm, 1'b0, seq_running};
                8'h04: m_rdata = m_test;
                8'h08: m_rdata = 32'(m_slot);
                8'h0C: m_rdata = mem[m_slot][31:0];
                8'h10: m_rdata = mem[m_slot][63:32];
                8'h14: m_rdata = mem[m_slot][95:64];
                8'h18: m_rdata = mem[m_slot][127:96];
                8'h1C: m_rdata = m_inv;
                8'h20: m_rdata = VER;
                default: m_rdata = 0;
            endcase
            m_we = bus_wr && bus_addr == 8'h18;
            if (m_we) begin
                m_wdata = {bus_wdata, m_hi, m_med, m_lo};
                m_waddr = m_slot;
            end
            if (bus_wr) case (bus_addr)
                8'h00: begin m_arm = bus_wdata[2]; m_hold = bus_wdata[3]; end
                8'h04: m_test = bus_wdata;
                8'h08: m_slot = bus_wdata[SW-1:0];
                8'h0C: m_lo = bus_wdata;
                8'h10: m_med = bus_wdata;
                8'h14: m_hi = bus_wdata;
                8'h1C: m_inv = bus_wdata;
                default: ;
            endcase
            m_start = (sw || ex) && !hold_nx && !seq_running && !m_start;
            e3 = e2; e2 = e1; e1 = ext_start;
        end
        #2;
        if (!finished) begin
            chk("R5 model rdata", bus_rdata, m_rdata);
            chk("R13 model start", seq_start, m_start);
            chk("R9 model reset", seq_reset, m_hold);
            chk("R4 model we", prog_we, m_we);
            if (m_we) chk("R4 model commit", {prog_waddr, prog_wdata}, {m_waddr, m_wdata});
            chk("R10 model chan", chan_out, pat_in ^ m_inv);
            chk("R3 model raddr", mem_raddr, m_slot);
        end
    end

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1;
        @(negedge clk); d = bus_rdata; bus_rd = 0;
    endtask

    task automatic rdchk(string tag, logic [7:0] a, logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(tag, d, exp);
    endtask

    task automatic summary();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 rdata", bus_rdata, 0);
        chk("R1 start", seq_start, 0);
        chk("R1 reset", seq_reset, 0);
        chk("R1 we", prog_we, 0);
        rst_n = 1;
        pat_in = 32'h1234_5678;
        @(negedge clk);
        chk("R1 chan", chan_out, 32'h1234_5678);
        rdchk("R1 ctrl", 8'h00, 0);

        wr(8'h04, 32'hBEEF_BEEF);
        rdchk("R2 scratch", 8'h04, 32'hBEEF_BEEF);
        wr(8'h04, 32'h1234_5678);
        rdchk("R2 scratch2", 8'h04, 32'h1234_5678);

        wr(8'h08, 32'hFFFF_FFFF);
        rdchk("R3 slot trunc", 8'h08, 32'h0000_0FFF);
        chk("R3 raddr", mem_raddr, 12'hFFF);
        wr(8'h08, 32'd5);

        wr(8'h0C, 32'h1111_0001);
        chk("R4 no commit lo", prog_we, 0);
        wr(8'h10, 32'h2222_0002);
        wr(8'h14, 32'h3333_0003);
        chk("R4 no commit hi", prog_we, 0);
        @(negedge clk); bus_addr = 8'h18; bus_wdata = 32'h4444_0004; bus_wr = 1;
        @(negedge clk); bus_wr = 0;
        chk("R4 commit we", prog_we, 1);
        chk("R4 commit addr", prog_waddr, 12'd5);
        chk("R4 commit data", prog_wdata, 128'h4444_0004_3333_0003_2222_0002_1111_0001);
        @(negedge clk);
        chk("R4 pulse ends", prog_we, 0);
        rdchk("R5 word0", 8'h0C, 32'h1111_0001);
        rdchk("R5 word1", 8'h10, 32'h2222_0002);
        rdchk("R5 word2", 8'h14, 32'h3333_0003);
        rdchk("R5 word3", 8'h18, 32'h4444_0004);
        wr(8'h08, 32'd6);
        rdchk("R5 other slot", 8'h0C, 0);

        wr(8'h00, 32'h1);
        chk("R6 sw start", seq_start, 1);
        @(negedge clk);
        chk("R13 pulse one cycle", seq_start, 0);
        seq_running = 1;
        rdchk("R6 running bit", 8'h00, 32'h1);
        wr(8'h00, 32'h1);
        chk("R8 no start running", seq_start, 0);
        seq_running = 0;

        wr(8'h00, 32'h4);
        rdchk("R6 arm readback", 8'h00, 32'h4);
        wr(8'h00, 32'h5);
        chk("R7 sw ignored armed", seq_start, 0);
        repeat (2) @(negedge clk);
        ext_start = 1;
        @(negedge clk); chk("R7 latency a", seq_start, 0);
        @(negedge clk); chk("R7 latency b", seq_start, 0);
        @(negedge clk); chk("R7 ext start", seq_start, 1);
        @(negedge clk); chk("R13 ext single", seq_start, 0);
        ext_start = 0;
        repeat (3) @(negedge clk);
        seq_running = 1;
        ext_start = 1;
        repeat (5) @(negedge clk);
        chk("R8 ext while running", seq_start, 0);
        ext_start = 0; seq_running = 0;
        wr(8'h00, 32'h0);
        repeat (3) @(negedge clk);
        ext_start = 1;
        repeat (5) @(negedge clk);
        chk("R8 ext unarmed", seq_start, 0);
        ext_start = 0;

        wr(8'h00, 32'h8);
        chk("R9 reset level", seq_reset, 1);
        rdchk("R9 hold readback", 8'h00, 32'h8);
        wr(8'h00, 32'h9);
        chk("R9 blocked", seq_start, 0);
        wr(8'h00, 32'hC);
        repeat (3) @(negedge clk);
        ext_start = 1;
        repeat (5) @(negedge clk);
        chk("R9 ext blocked", seq_start, 0);
        ext_start = 0;
        wr(8'h00, 32'h1);
        chk("R9 release start", seq_start, 1);
        chk("R9 released", seq_reset, 0);

        wr(8'h1C, 32'hA5A5_0F0F);
        pat_in = 32'hFFFF_0000;
        @(negedge clk);
        chk("R10 invert", chan_out, 32'h5A5A_0F0F);
        rdchk("R10 readback", 8'h1C, 32'hA5A5_0F0F);

        rdchk("R11 version", 8'h20, VER);
        wr(8'h20, 32'h0);
        rdchk("R11 version kept", 8'h20, VER);

        rdchk("R12 unmapped", 8'h24, 0);
        rdchk("R12 misaligned", 8'h05, 0);
        wr(8'h05, 32'hDEAD_0000);
        wr(8'h1D, 32'h0000_0001);
        wr(8'h09, 32'h0000_0001);
        rdchk("R12 test unchanged", 8'h04, 32'h1234_5678);
        rdchk("R12 inv unchanged", 8'h1C, 32'hA5A5_0F0F);
        rdchk("R12 slot unchanged", 8'h08, 32'd6);
        @(negedge clk);
        chk("R13 idle rdata", bus_rdata, 0);

        repeat (3) @(negedge clk);
        summary();
    end
endmodule